// File: doc/BRIEF.md
# One-Bit Message Compress and Pack

This block turns a polynomial of 256 coefficients, each reduced modulo Q = 3329, into a 256-bit message. It reads the coefficients one at a time from a synchronous memory read port. It reduces each one to a single bit by testing whether it lies in the interval (Q/4, 3Q/4]. It then places that bit in a message register: coefficient i becomes message bit i.

A run begins with a one-cycle `start_i` pulse. The block latches the polynomial's slot number and the direction. It then steps through the coefficients in a two-phase rhythm:

- In the first cycle it presents the memory address.
- In the second cycle it takes the returned word and moves to the next index.

After the last coefficient it raises `done_o`. The message stays on `msg_o` until the next start.

The same sequencer also serves the reverse direction. With `mode_i` high, the block loads `msg_i` at start. It then writes one coefficient per two cycles back into the slot: 1665 for a set bit and 0 for a clear bit. Memory address and write port share `mem_addr_o`. The coefficient count must be a power of two.

Top module: `msgpack_top`

## Requirements
- R1: In compress mode (`mode_i` = 0 at start) a coefficient w yields bit 1 exactly when 832 < w <= 2496 and bit 0 otherwise. This equals round(2w/3329) mod 2.
- R2: Message bit i comes from coefficient i, so byte j of `msg_o` (bits 8j+7..8j) holds coefficients 8j..8j+7, with the lowest index in bit 0.
- R3: `mem_addr_o` is slot*256 + i for coefficient i, where slot is `base_slot_i` sampled at start. Each address is held for exactly two cycles and the index rises by one after each pair.
- R4: `done_o` is low for the 512 cycles that follow the start edge and goes high at the 512th edge after it. It then stays high, with `msg_o` unchanged, until the next start.
- R5: After reset, `done_o`, `busy_o` and `wr_en_o` are 0 and `msg_o` is all zero. A start in compress mode clears `done_o` and `msg_o` on its own edge.
- R6: In expand mode (`mode_i` = 1 at start), `msg_o` takes `msg_i`. For every i the block writes 1665 (bit i = 1) or 0 (bit i = 0) to address slot*256 + i, pulsing `wr_en_o` exactly 256 times. In compress mode `wr_en_o` never pulses.
- R7: A start during a run abandons that run and begins a new one from index 0, using the new slot and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that begins a run |
| mode_i | input | 1 | Direction sampled at start: 0 compress, 1 expand |
| base_slot_i | input | 4 | Polynomial slot in memory, sampled at start |
| msg_i | input | 256 | Message loaded at start in expand mode |
| rd_data_i | input | 12 | Memory read data, one cycle after the address |
| mem_addr_o | output | 12 | Shared read/write address, slot*256 + index |
| wr_en_o | output | 1 | Coefficient write strobe (expand mode) |
| wr_data_o | output | 12 | Expanded coefficient, 1665 or 0 |
| msg_o | output | 256 | Packed message |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run completed |

## Verification
The compress path is driven with several whole polynomials:

- An all-zero polynomial and an all-1665 polynomial show that the interval test and the bit packing can produce both a solid 0 and a solid 1 message.
- A polynomial that repeats the values 832, 833, 2496, 2497, 0, 3328, 1664 and 1665 hits each edge of the interval from both sides. Because it repeats every eight coefficients, it also shows whether bits land in the right byte.
- A linear ramp and a quadratic scramble give irregular messages, where a slip of one position in the index or the address would show.

Different slots separate address formation from the data path. The expand direction and a mid-run restart are covered by directed tests.

// File: rtl/msgpack_pkg.sv
package msgpack_pkg;
  localparam int unsigned Q      = 3329;
  localparam int          CW     = 12;
  localparam int unsigned LO_EDGE = Q / 4;          // lower bound, excluded
  localparam int unsigned HI_EDGE = (3 * Q) / 4;    // upper bound, included
  localparam int unsigned HALF_Q  = (Q + 1) / 2;    // image of a set bit

  typedef logic [CW-1:0] coef_t;

  // One-bit compression as an interval test
  function automatic logic compress1(coef_t w);
    return (32'(w) > LO_EDGE) && (32'(w) <= HI_EDGE);
  endfunction

  // One-bit expansion
  function automatic coef_t expand1(logic b);
    return b ? coef_t'(HALF_Q) : '0;
  endfunction
endpackage

// File: rtl/msgpack_seq.sv
module msgpack_seq #(
  parameter int N  = 256,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic [IW-1:0] idx_o,
  output logic          phase_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          step_o
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_o   <= '0;
      phase_o <= 1'b0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
    end else if (start_i) begin
      idx_o   <= '0;
      phase_o <= 1'b0;
      busy_o  <= 1'b1;
      done_o  <= 1'b0;
    end else if (busy_o) begin
      if (!phase_o) begin
        phase_o <= 1'b1;
      end else begin
        phase_o <= 1'b0;
        if (idx_o == LAST) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          idx_o <= idx_o + 1'b1;
        end
      end
    end
  end

  // data-return phase: the word for idx_o is on the read port
  assign step_o = busy_o && phase_o;
endmodule

// File: rtl/msgpack_bits.sv
module msgpack_bits #(
  parameter int N  = 256,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          load_i,
  input  logic [N-1:0]  load_val_i,
  input  logic          set_i,
  input  logic [IW-1:0] set_idx_i,
  input  logic          set_val_i,
  output logic [N-1:0]  msg_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        msg_o <= '0;
    else if (clear_i)  msg_o <= '0;
    else if (load_i)   msg_o <= load_val_i;
    else if (set_i)    msg_o[set_idx_i] <= set_val_i;
  end
endmodule

// File: rtl/msgpack_top.sv
module msgpack_top
  import msgpack_pkg::*;
#(
  parameter int N      = 256,
  parameter int SLOT_W = 4,
  parameter int IW     = $clog2(N),
  parameter int AW     = SLOT_W + IW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [SLOT_W-1:0] base_slot_i,
  input  logic [N-1:0]      msg_i,
  input  logic [CW-1:0]     rd_data_i,
  output logic [AW-1:0]     mem_addr_o,
  output logic              wr_en_o,
  output logic [CW-1:0]     wr_data_o,
  output logic [N-1:0]      msg_o,
  output logic              busy_o,
  output logic              done_o
);
  logic              mode_q;
  logic [SLOT_W-1:0] base_q;
  logic [IW-1:0]     idx;
  logic              phase;
  logic              busy;
  logic              step_ev;   // a coefficient is handled this cycle
  logic              take_ev;   // compress: bit captured
  logic              put_ev;    // expand: coefficient written
  logic              cbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      base_q <= '0;
    end else if (start_i) begin
      mode_q <= mode_i;
      base_q <= base_slot_i;
    end
  end

  msgpack_seq #(.N(N), .IW(IW)) seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .idx_o   (idx),
    .phase_o (phase),
    .busy_o  (busy),
    .done_o  (done_o),
    .step_o  (step_ev)
  );

  assign take_ev = step_ev && !mode_q;
  assign put_ev  = step_ev && mode_q;
  assign cbit    = compress1(rd_data_i);

  msgpack_bits #(.N(N), .IW(IW)) bits_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (start_i && !mode_i),
    .load_i     (start_i && mode_i),
    .load_val_i (msg_i),
    .set_i      (take_ev),
    .set_idx_i  (idx),
    .set_val_i  (cbit),
    .msg_o      (msg_o)
  );

  // slot*N + index, N a power of two
  assign mem_addr_o = {base_q, idx};
  assign wr_en_o    = put_ev;
  assign wr_data_o  = expand1(msg_o[idx]);
  assign busy_o     = busy;
endmodule

// File: rtl/msgpack_chk.sv
module msgpack_chk
  import msgpack_pkg::*;
#(
  parameter int N  = 256,
  parameter int IW = $clog2(N),
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          mode_q,
  input logic          step_ev,
  input logic          busy,
  input logic [IW-1:0] idx,
  input logic          phase,
  input logic [AW-1:0] mem_addr_o,
  input logic [CW-1:0] rd_data_i,
  input logic          done_o,
  input logic [N-1:0]  msg_o,
  input logic          wr_en_o,
  input logic [CW-1:0] wr_data_o
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  // R1: a coefficient at or above Q is a protocol violation
  a_r1_data_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && !mode_q) |-> (32'(rd_data_i) < Q));

  // R2: the captured bit lands at the index it was read from
  a_r2_bit_placed: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && !mode_q && !start_i) |=>
      (msg_o[$past(idx)] == compress1($past(rd_data_i))));

  // R3: address held across both phases
  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !phase && !start_i) |=> $stable(mem_addr_o));

  // R3: index advances by one per handled coefficient
  a_r3_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && idx != LAST && !start_i) |=> (idx == $past(idx) + 1'b1));

  // R4: done follows the last coefficient
  a_r4_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && idx == LAST && !start_i) |=> done_o);

  // R7: a start always restarts from index 0 in phase 0
  a_r7_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!done_o && idx == '0 && !phase));

  // R6: written coefficients are only the two expansion images
  a_r6_wr_values: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (wr_data_o == '0 || 32'(wr_data_o) == HALF_Q));
endmodule

bind msgpack_top msgpack_chk #(.N(N), .IW(IW), .AW(AW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .mode_q     (mode_q),
  .step_ev    (step_ev),
  .busy       (busy),
  .idx        (idx),
  .phase      (phase),
  .mem_addr_o (mem_addr_o),
  .rd_data_i  (rd_data_i),
  .done_o     (done_o),
  .msg_o      (msg_o),
  .wr_en_o    (wr_en_o),
  .wr_data_o  (wr_data_o)
);

// File: tb/msgpack_top_tb_top.sv
`timescale 1ns/1ps
module msgpack_top_tb_top;
  localparam int N = 256;
  localparam int Q = 3329;
  localparam int HALF = 1665;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic mode_i = 1'b0;
  logic [3:0] base_slot_i = '0;
  logic [N-1:0] msg_i = '0;
  logic [11:0] rd_data_i;
  logic [11:0] mem_addr_o;
  logic wr_en_o;
  logic [11:0] wr_data_o;
  logic [N-1:0] msg_o;
  logic busy_o, done_o;

  int n_tests = 0;
  int n_fail = 0;
  int wcount = 0;

  logic [11:0] mem [0:4095];
  logic [11:0] rd_q = '0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    rd_q <= mem[mem_addr_o];
    if (wr_en_o) begin
      mem[mem_addr_o] <= wr_data_o;
      wcount <= wcount + 1;
    end
  end
  assign rd_data_i = rd_q;

  msgpack_top dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .base_slot_i(base_slot_i), .msg_i(msg_i), .rd_data_i(rd_data_i),
    .mem_addr_o(mem_addr_o), .wr_en_o(wr_en_o), .wr_data_o(wr_data_o),
    .msg_o(msg_o), .busy_o(busy_o), .done_o(done_o)
  );

  // stimulus table: {pattern, slot}
  localparam logic [7:0] VEC [0:5] = '{8'h00, 8'h13, 8'h25, 8'h3F, 8'h47, 8'h32};

  function automatic int coef(int pat, int i);
    case (pat)
      0: return 0;
      1: return HALF;
      2: return (i * 13) % Q;
      3: begin
        case (i % 8)
          0: return 832;  1: return 833;  2: return 2496; 3: return 2497;
          4: return 0;    5: return 3328; 6: return 1664; default: return 1665;
        endcase
      end
      default: return (i * i * 97 + 41 * i + 7) % Q;
    endcase
  endfunction

  // rounding form: round(2w/Q) mod 2
  function automatic logic ref_bit(int w);
    return ((((4 * w) + Q) / (2 * Q)) % 2) == 1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start(input logic md, input int slot);
    @(negedge clk);
    start_i = 1'b1; mode_i = md; base_slot_i = 4'(slot);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // full compress run with cycle-exact address and done checks
  task automatic run_compress(input int pat, input int slot);
    logic [N-1:0] exp;
    int bad_addr;
    int early;
    for (int i = 0; i < N; i++) begin
      mem[slot * N + i] = 12'(coef(pat, i));
      exp[i] = ref_bit(coef(pat, i));
    end
    pulse_start(1'b0, slot);
    bad_addr = 0; early = 0;
    for (int t = 0; t < 2 * N; t++) begin
      if (mem_addr_o != 12'(slot * N + t / 2)) bad_addr++;
      if (done_o) early++;
      @(negedge clk);
    end
    check(bad_addr == 0, "R3", "address sequence mismatches",
          N'(bad_addr), '0);
    check(early == 0 && done_o == 1'b1, "R4", "done timing",
          N'({early[7:0], done_o}), N'(1));
    check(msg_o == exp, "R1/R2", $sformatf("message pat %0d slot %0d", pat, slot),
          msg_o, exp);
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    wait (0);
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] held;
    logic [N-1:0] pat_msg;
    int w0, bad;
    for (int a = 0; a < 4096; a++) mem[a] = '0;
    repeat (3) @(negedge clk);
    // R5: reset state
    check(done_o == 1'b0, "R5", "done after reset", N'(done_o), '0);
    check(busy_o == 1'b0, "R5", "busy after reset", N'(busy_o), '0);
    check(msg_o == '0, "R5", "msg after reset", msg_o, '0);
    check(wr_en_o == 1'b0, "R5", "wr_en after reset", N'(wr_en_o), '0);
    rst_n = 1'b1;
    @(negedge clk);

    w0 = wcount;
    for (int v = 0; v < 6; v++) run_compress(int'(VEC[v][7:4]), int'(VEC[v][3:0]));
    check(wcount == w0, "R6", "writes during compress", N'(wcount - w0), '0);

    // R4: done and message hold after completion
    held = msg_o;
    repeat (20) @(negedge clk);
    check(done_o == 1'b1 && msg_o == held, "R4", "hold after done", msg_o, held);

    // R5: start in compress mode clears message and done on its edge
    pulse_start(1'b0, 2);
    check(msg_o == '0 && done_o == 1'b0, "R5", "clear on start",
          msg_o, '0);

    // R7: restart mid-run with another slot and pattern
    repeat (100) @(negedge clk);
    run_compress(3, 6);

    // R6: expand direction
    for (int i = 0; i < N; i++) mem[2 * N + i] = 12'd999;
    pat_msg = {8{32'hC3A5_0F96}};
    msg_i = pat_msg;
    w0 = wcount;
    pulse_start(1'b1, 2);
    for (int t = 0; t < 3 * N && !done_o; t++) @(negedge clk);
    @(negedge clk);
    bad = 0;
    for (int i = 0; i < N; i++)
      if (mem[2 * N + i] != (pat_msg[i] ? 12'(HALF) : 12'd0)) bad++;
    check(bad == 0, "R6", "expanded coefficients mismatches", N'(bad), '0);
    check(wcount - w0 == N, "R6", "write count", N'(wcount - w0), N'(N));
    check(msg_o == pat_msg, "R6", "message loaded", msg_o, pat_msg);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule